// File: doc/BRIEF.md
# Nibble-Opcode Single-Cycle Execution Core

A small 16-bit execution core that runs one byte-wide instruction per clock. The top four bits of the instruction byte pick the operation. The low four bits name one of sixteen 16-bit registers. Two of those registers have fixed roles: the accumulator at index 0 and the condition register at index 1. The core supports four operations. It can invert a register in place. It can branch PC-relative when the condition register is non-negative. It can branch PC-relative when the condition register is nonzero. It can load the accumulator from one of sixteen input ports. Every other opcode only advances the program counter.

The program counter drives the instruction address directly. Memory returns the byte at that address together with a valid flag. The core consumes an instruction only at a rising edge where the valid flag is high. While the flag is low, the core waits and holds all of its state, so memory can stall it for any number of cycles. The core never stalls the memory in turn, so there is no ready signal. A branch jumps by the run-time contents of the register named in the opcode, not by an immediate. The condition is always read from the fixed condition register.

Top module: `nib_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the program counter to 0 and clears all sixteen registers, including the accumulator and the condition register.
- R2: Opcode 4'hA (bits 7:4) inverts every bit of the register selected by bits 3:0, writes the result back to that register, and advances the program counter by 1.
- R3: Opcode 4'hB branches when bit 15 of the condition register (index 1) is 0: the program counter becomes PC + R[X]. When that bit is 1, the program counter becomes PC + 1.
- R4: Opcode 4'hC branches when the condition register is not 16'h0000: the program counter becomes PC + R[X]. When it is zero, the program counter becomes PC + 1.
- R5: Opcode 4'hD loads the accumulator (index 0) with input port X, taken from `port_bank[16*X +: 16]`, and advances the program counter by 1.
- R6: Any opcode other than 4'hA to 4'hD advances the program counter by 1 and changes no register.
- R7: An accepted instruction takes effect at the rising edge where it is presented. The next instruction address is the updated program counter.
- R8: While `imem_valid` is low, the program counter and every register hold their values.
- R9: The branch sum is taken modulo 2^16, so a register that holds a negative two's-complement value gives a backward branch. A zero value gives a branch to the same address.
- R10: A branch changes only the program counter. The only register a complement or port read changes is its own destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_valid | input | 1 | Instruction byte on `imem_data` is valid this cycle |
| imem_data | input | 8 | Instruction byte at `imem_addr` |
| port_bank | input | 256 | Sixteen 16-bit input ports; port k is bits 16k+15:16k |
| imem_addr | output | 16 | Program counter, used as the instruction address |
| a_reg | output | 16 | Accumulator (register 0) |
| i_reg | output | 16 | Condition register (register 1) |

## Verification
Every result of an accepted instruction is due at the first rising edge after the instruction is presented with `imem_valid` high. This applies to the new instruction address, the accumulator and the condition register alike. After a stalled cycle, the same values are due unchanged at that edge. The bench drives inputs and samples outputs at falling edges. Each expected item in its queue carries the cycle number at which it becomes due, so it is compared at the falling edge that follows that one rising edge. Inverts and branches on registers other than 0 and 1 are observed through the program counter, because the branch offset reveals the register's value.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int OPC_W = 4;
  localparam int IDX_W = 4;
  localparam int INSTR_W = OPC_W + IDX_W;

  localparam logic [OPC_W-1:0] OPC_INV = 4'hA;
  localparam logic [OPC_W-1:0] OPC_BRP = 4'hB;
  localparam logic [OPC_W-1:0] OPC_BRN = 4'hC;
  localparam logic [OPC_W-1:0] OPC_INP = 4'hD;

  typedef struct packed {
    logic             inv;
    logic             brp;
    logic             brn;
    logic             inp;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = instr[INSTR_W-1 -: OPC_W];
    dec.idx = instr[IDX_W-1:0];
    dec.inv = valid && (opc == OPC_INV);
    dec.brp = valid && (opc == OPC_BRP);
    dec.brn = valid && (opc == OPC_BRN);
    dec.inp = valid && (opc == OPC_INP);
  end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int DW    = 16,
  parameter int NREG  = 16,
  parameter int A_IDX = 0,
  parameter int I_IDX = 1,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] i_q
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];
  assign a_q     = regs[A_IDX];
  assign i_q     = regs[I_IDX];
endmodule

// File: rtl/nib_nextpc.sv
module nib_nextpc #(
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic          valid,
  input  logic          brp,
  input  logic          brn,
  input  logic [DW-1:0] cond,
  input  logic [DW-1:0] offset,
  input  logic [PW-1:0] pc,
  output logic [PW-1:0] pc_next
);
  logic take;

  always_comb begin
    take = (brp && !cond[DW-1]) || (brn && (cond != '0));
    if (!valid)
      pc_next = pc;
    else if (take)
      pc_next = pc + PW'(offset);
    else
      pc_next = pc + PW'(1);
  end
endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16,
  parameter int A_IDX  = 0,
  parameter int I_IDX  = 1,
  localparam int NREG  = 1 << IDX_W,
  localparam int PB_W  = NREG * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_valid,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic [PB_W-1:0]    port_bank,
  output logic [PC_W-1:0]    imem_addr,
  output logic [DATA_W-1:0]  a_reg,
  output logic [DATA_W-1:0]  i_reg
);
  dec_t              dec;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [DATA_W-1:0] rd_val, port_val, wr_val;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_en;

  nib_decode u_dec (
    .valid (imem_valid),
    .instr (imem_data),
    .dec   (dec)
  );

  assign port_val = port_bank[DATA_W*dec.idx +: DATA_W];

  always_comb begin
    wr_en  = dec.inv || dec.inp;
    wr_idx = dec.inp ? IDX_W'(A_IDX) : dec.idx;
    wr_val = dec.inp ? port_val : ~rd_val;
  end

  nib_regfile #(.DW(DATA_W), .NREG(NREG), .A_IDX(A_IDX), .I_IDX(I_IDX)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_val),
    .rd_idx  (dec.idx),
    .rd_data (rd_val),
    .a_q     (a_reg),
    .i_q     (i_reg)
  );

  nib_nextpc #(.PW(PC_W), .DW(DATA_W)) u_npc (
    .valid   (imem_valid),
    .brp     (dec.brp),
    .brn     (dec.brn),
    .cond    (i_reg),
    .offset  (rd_val),
    .pc      (pc_q),
    .pc_next (pc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign imem_addr = pc_q;
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk (
  input logic         clk,
  input logic         rst,
  input logic         imem_valid,
  input logic [7:0]   imem_data,
  input logic [255:0] port_bank,
  input logic [15:0]  imem_addr,
  input logic [15:0]  a_reg,
  input logic [15:0]  i_reg
);
  logic [3:0]  opc;
  logic [15:0] sel_port;
  assign opc      = imem_data[7:4];
  assign sel_port = port_bank[16*imem_data[3:0] +: 16];

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == 16'h0) && (a_reg == 16'h0) && (i_reg == 16'h0));
  // R8
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !imem_valid |=> $stable(imem_addr) && $stable(a_reg) && $stable(i_reg));
  // R5
  p_port_load_r5: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && opc == 4'hD) |=> a_reg == $past(sel_port));
  // R6, R2: every non-branch opcode steps by one
  p_seq_step_r6: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && opc != 4'hB && opc != 4'hC) |=> imem_addr == $past(imem_addr) + 16'h1);
  // R10
  p_branch_regs_r10: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && (opc == 4'hB || opc == 4'hC)) |=> $stable(a_reg) && $stable(i_reg));
  // R3
  p_brp_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && opc == 4'hB && i_reg[15]) |=> imem_addr == $past(imem_addr) + 16'h1);
  // R4
  p_brn_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && opc == 4'hC && i_reg == 16'h0) |=> imem_addr == $past(imem_addr) + 16'h1);
  // R2
  p_inv_cond_r2: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && imem_data == 8'hA1) |=> i_reg == ~$past(i_reg));
endmodule

bind nib_core nib_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_valid (imem_valid),
  .imem_data  (imem_data),
  .port_bank  (port_bank),
  .imem_addr  (imem_addr),
  .a_reg      (a_reg),
  .i_reg      (i_reg)
);

// File: tb/test_nib_core.sv
`timescale 1ns/1ps
module test_nib_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         imem_valid = 1'b0;
  logic [7:0]   imem_data;
  logic [255:0] port_bank;
  logic [15:0]  imem_addr, a_reg, i_reg;
  logic [7:0]   rom [256];

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic [15:0] pc, a, i;
    string       tag;
  } exp_t;
  exp_t sb [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign imem_data = rom[imem_addr[7:0]];

  nib_core i_nib_core (
    .clk        (clk),
    .rst        (rst),
    .imem_valid (imem_valid),
    .imem_data  (imem_data),
    .port_bank  (port_bank),
    .imem_addr  (imem_addr),
    .a_reg      (a_reg),
    .i_reg      (i_reg)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: compares each queued item at the falling edge after its due edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(imem_addr, e.pc, {e.tag, " pc"});
      chk(a_reg, e.a, {e.tag, " A"});
      chk(i_reg, e.i, {e.tag, " I"});
    end
  end

  // driver: present one cycle and queue its expected outcome
  task automatic step(input bit v, input logic [15:0] pc, input logic [15:0] a,
                      input logic [15:0] i, input string tag);
    exp_t e;
    e.due = cyc + 1; e.pc = pc; e.a = a; e.i = i; e.tag = tag;
    sb.push_back(e);
    imem_valid = v;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) rom[k] = 8'h00;
    for (int k = 0; k < 16; k++) port_bank[16*k +: 16] = 16'(k * 16'h0101);
    port_bank[16*3 +: 16] = 16'h0005;
    port_bank[16*7 +: 16] = 16'hFFF9;
    port_bank[16*9 +: 16] = 16'h000A;
    rom[0] = 8'hD3; rom[1] = 8'h25; rom[2] = 8'hB0;
    rom[3] = 8'hA0; rom[4] = 8'hA0; rom[5] = 8'hA0; rom[6] = 8'hD9;
    rom[7] = 8'hC0; rom[8] = 8'hA1; rom[9] = 8'hB0; rom[10] = 8'hA0;
    rom[11] = 8'hA0; rom[12] = 8'hD7; rom[13] = 8'hC0;
    rom[17] = 8'hF3; rom[18] = 8'hA1; rom[19] = 8'hC0;
    rom[20] = 8'hA5; rom[21] = 8'hB5;

    repeat (3) @(negedge clk);
    chk(imem_addr, 16'h0, "R1 reset pc");
    chk(a_reg, 16'h0, "R1 reset A");
    chk(i_reg, 16'h0, "R1 reset I");
    rst = 1'b0;

    step(1, 16'd1,  16'h0005, 16'h0000, "R5 port 3 load");
    step(1, 16'd2,  16'h0005, 16'h0000, "R6 opcode 2 no-op");
    step(1, 16'd7,  16'h0005, 16'h0000, "R3 taken I=0000 R10");
    step(1, 16'd8,  16'h0005, 16'h0000, "R4 not taken I=0");
    step(0, 16'd8,  16'h0005, 16'h0000, "R8 stall");
    step(1, 16'd9,  16'h0005, 16'hFFFF, "R2 invert I");
    step(1, 16'd10, 16'h0005, 16'hFFFF, "R3 not taken I=FFFF");
    step(1, 16'd11, 16'hFFFA, 16'hFFFF, "R2 invert A");
    step(1, 16'd12, 16'h0005, 16'hFFFF, "R2 invert A back");
    step(1, 16'd13, 16'hFFF9, 16'hFFFF, "R5 port 7 load");
    step(1, 16'd6,  16'hFFF9, 16'hFFFF, "R9 backward branch");
    step(1, 16'd7,  16'h000A, 16'hFFFF, "R5 port 9 load R7");
    step(0, 16'd7,  16'h000A, 16'hFFFF, "R8 stall before branch");
    step(1, 16'd17, 16'h000A, 16'hFFFF, "R4 taken I!=0");
    step(1, 16'd18, 16'h000A, 16'hFFFF, "R6 opcode F no-op");
    step(1, 16'd19, 16'h000A, 16'h0000, "R2 invert I back");
    step(1, 16'd20, 16'h000A, 16'h0000, "R4 not taken I=0 again");
    step(1, 16'd21, 16'h000A, 16'h0000, "R2 invert R5");
    step(1, 16'd20, 16'h000A, 16'h0000, "R9 branch by FFFF");
    step(1, 16'd21, 16'h000A, 16'h0000, "R2 invert R5 back");
    step(1, 16'd21, 16'h000A, 16'h0000, "R3 zero offset self");
    imem_valid = 1'b0;
    @(negedge clk);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(imem_addr, 16'h0, "R1 mid-run reset pc");
    chk(a_reg, 16'h0, "R1 mid-run reset A");
    chk(i_reg, 16'h0, "R1 mid-run reset I");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule